// File: doc/BRIEF.md
# Lane and Bit-Count Unit

This block is a 64-bit execution unit for bit-counting and small packed-lane operations. Each cycle it can accept one operation made of two operands, a 7-bit function code, and a flag. The flag says whether the instruction's first register field names the hardwired zero register (index 31). The operations are: counting the set bits, counting leading zeros and trailing zeros, sign-extending a byte or a halfword, summing absolute byte differences, spreading bytes out to wider lanes and gathering them back, and signed or unsigned minimum and maximum on byte or halfword lanes.

The result, an illegal-operation flag and an output valid appear exactly one clock after the operation is accepted. A code that is not recognised, or a sign-extension issued with the wrong first register field, returns a zero result and raises the illegal flag. The issue logic can then raise a fault for that instruction.

Top module: `lane_bitops_unit`

## Requirements
- R1: Code 0x00 returns opB[7:0] sign-extended to 64 bits, and code 0x01 returns opB[15:0] sign-extended. Both are legal only when aFieldIsZeroReg is 1.
- R2: Code 0x30 returns the number of 1 bits in opB.
- R3: Code 0x32 returns the count of leading zeros of opB, counted from bit 63 downward. Code 0x33 returns the count of trailing zeros, counted from bit 0 upward. An opB of zero gives 64 for both codes.
- R4: Code 0x31 returns the sum of |opA byte i − opB byte i| over the eight unsigned byte lanes.
- R5: Code 0x34 copies opB byte i (i = 0..3) into result bits [16i+7:16i]. Code 0x35 copies opB byte i (i = 0..1) into result bits [32i+7:32i]. All other result bits are zero.
- R6: Code 0x36 copies opB bits [16i+7:16i] into result byte i (i = 0..3). Code 0x37 copies opB bits [32i+7:32i] into result byte i (i = 0..1). All other result bits are zero.
- R7: The minimum codes are 0x38 (signed bytes), 0x39 (signed halfwords), 0x3a (unsigned bytes) and 0x3b (unsigned halfwords). Each lane of the result holds the smaller of the opA and opB lanes.
- R8: The maximum codes are 0x3c (unsigned bytes), 0x3d (unsigned halfwords), 0x3e (signed bytes) and 0x3f (signed halfwords). Each lane of the result holds the larger of the opA and opB lanes.
- R9: The illegal flag is 1 and the result is zero in two cases: a code that is not listed in R1–R8, or code 0x00 or 0x01 with aFieldIsZeroReg equal to 0.
- R10: result and illegal are updated one clock after an accepted operation (inValid = 1), and outValid equals inValid of the previous cycle. When inValid = 0, result and illegal keep their values. After reset, outValid, result and illegal are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operation is presented this cycle |
| funcCode | input | 7 | Function code |
| aFieldIsZeroReg | input | 1 | The first register field is 31 |
| opA | input | 64 | Operand A |
| opB | input | 64 | Operand B |
| outValid | output | 1 | Result is valid this cycle |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered illegal-operation flag |

## Verification
The unit holds almost no state. The only lasting errors are a stale output register or a valid bit out of step with inValid. Either one shows at the ports on the very next cycle, as a wrong value or a wrong timing of outValid. A wrong decode or a faulty count tree also shows up in the result of the operation that hits it, one cycle after issue. The bench sweeps every one of the 128 codes, with the flag both set and clear, across corner and pseudo-random operands. Each result is compared with an arithmetic model.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

  typedef enum logic [3:0] {
    K_NONE,
    K_SEXT,
    K_POP,
    K_LEAD,
    K_TRAIL,
    K_SAD,
    K_SPREAD,
    K_GATHER,
    K_MINMAX
  } opKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    opKind_e kind;
    logic    wide;      // halfword sext, 32-bit spread/gather, 16-bit lanes
    logic    isSigned;  // signed lane compare
    logic    pickMax;   // max instead of min
    logic    illegal;
  } laneCtl_t;

endpackage

// File: rtl/lbu_control.sv
module lbu_control
  import lbu_pkg::*;
(
  input  logic [6:0] funcCode,
  input  logic       aFieldIsZeroReg,
  output laneCtl_t   ctl
);

  always_comb begin
    ctl = '{kind: K_NONE, wide: 1'b0, isSigned: 1'b0, pickMax: 1'b0, illegal: 1'b1};
    unique casez (funcCode)
      7'h00, 7'h01: begin
        if (aFieldIsZeroReg) begin
          ctl.kind    = K_SEXT;
          ctl.wide    = funcCode[0];
          ctl.illegal = 1'b0;
        end
      end
      7'h30: begin ctl.kind = K_POP;   ctl.illegal = 1'b0; end
      7'h31: begin ctl.kind = K_SAD;   ctl.illegal = 1'b0; end
      7'h32: begin ctl.kind = K_LEAD;  ctl.illegal = 1'b0; end
      7'h33: begin ctl.kind = K_TRAIL; ctl.illegal = 1'b0; end
      7'h34, 7'h35: begin
        ctl.kind    = K_SPREAD;
        ctl.wide    = funcCode[0];
        ctl.illegal = 1'b0;
      end
      7'h36, 7'h37: begin
        ctl.kind    = K_GATHER;
        ctl.wide    = funcCode[0];
        ctl.illegal = 1'b0;
      end
      7'b01110??, 7'b01111??: begin
        // bit2: max; bit1 picks signedness (inverted between min and max); bit0: halfword
        ctl.kind     = K_MINMAX;
        ctl.wide     = funcCode[0];
        ctl.pickMax  = funcCode[2];
        ctl.isSigned = funcCode[2] ? funcCode[1] : ~funcCode[1];
        ctl.illegal  = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lbu_count_tree.sv
module lbu_count_tree #(
  parameter int W = 64
) (
  input  logic [W-1:0]         vecIn,
  output logic [$clog2(W):0]   leadZeros,
  output logic [$clog2(W):0]   trailZeros,
  output logic [$clog2(W):0]   onesCount
);

  localparam int STG = $clog2(W);
  localparam int CW  = STG + 1;

  // Halving priority tree from the top
  always_comb begin
    logic [W-1:0] work;
    work      = vecIn;
    leadZeros = '0;
    for (int s = STG - 1; s >= 0; s--) begin
      int half;
      half = 1 << s;
      if ((work >> (W - half)) == '0) begin
        leadZeros = leadZeros + CW'(half);
        work      = work << half;
      end
    end
    if (!work[W-1]) leadZeros = leadZeros + CW'(1);
  end

  // Halving priority tree from the bottom
  always_comb begin
    logic [W-1:0] work;
    work       = vecIn;
    trailZeros = '0;
    for (int s = STG - 1; s >= 0; s--) begin
      int half;
      half = 1 << s;
      if ((work & ({W{1'b1}} >> (W - half))) == '0) begin
        trailZeros = trailZeros + CW'(half);
        work       = work >> half;
      end
    end
    if (!work[0]) trailZeros = trailZeros + CW'(1);
  end

  always_comb begin
    onesCount = '0;
    for (int i = 0; i < W; i++) onesCount = onesCount + CW'(vecIn[i]);
  end

endmodule

// File: rtl/lbu_datapath.sv
module lbu_datapath
  import lbu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  laneCtl_t          ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] dpOut
);

  localparam int NB  = DATA_W / 8;
  localparam int NH  = DATA_W / 16;
  localparam int NW  = DATA_W / 32;
  localparam int CW  = $clog2(DATA_W) + 1;
  localparam int SW  = 8 + $clog2(NB);

  logic [CW-1:0] leadZeros, trailZeros, onesCount;

  lbu_count_tree #(.W(DATA_W)) countTree (
    .vecIn      (opB),
    .leadZeros  (leadZeros),
    .trailZeros (trailZeros),
    .onesCount  (onesCount)
  );

  // Sum of absolute byte differences
  logic [SW-1:0] sadSum;
  always_comb begin
    sadSum = '0;
    for (int i = 0; i < NB; i++) begin
      logic [7:0] aByte, bByte, diff;
      aByte  = opA[8*i +: 8];
      bByte  = opB[8*i +: 8];
      diff   = (aByte >= bByte) ? (aByte - bByte) : (bByte - aByte);
      sadSum = sadSum + SW'(diff);
    end
  end

  // Spread and gather between byte and 16/32-bit lanes
  logic [DATA_W-1:0] spread16, spread32, gather16, gather32;
  always_comb begin
    spread16 = '0;
    spread32 = '0;
    gather16 = '0;
    gather32 = '0;
    for (int i = 0; i < NH; i++) begin
      spread16[16*i +: 8] = opB[8*i +: 8];
      gather16[8*i +: 8]  = opB[16*i +: 8];
    end
    for (int i = 0; i < NW; i++) begin
      spread32[32*i +: 8] = opB[8*i +: 8];
      gather32[8*i +: 8]  = opB[32*i +: 8];
    end
  end

  // Lane min/max, one variant per lane width
  logic [DATA_W-1:0] mmRes [2];
  for (genvar g = 0; g < 2; g++) begin : gWidth
    localparam int LW = 8 << g;
    for (genvar l = 0; l < DATA_W / LW; l++) begin : gLane
      logic [LW-1:0] aLane, bLane;
      logic          aLtB, bLtA;
      assign aLane = opA[LW*l +: LW];
      assign bLane = opB[LW*l +: LW];
      assign aLtB  = $signed({ctl.isSigned & aLane[LW-1], aLane}) <
                     $signed({ctl.isSigned & bLane[LW-1], bLane});
      assign bLtA  = $signed({ctl.isSigned & bLane[LW-1], bLane}) <
                     $signed({ctl.isSigned & aLane[LW-1], aLane});
      assign mmRes[g][LW*l +: LW] = ctl.pickMax ? (bLtA ? aLane : bLane)
                                                : (aLtB ? aLane : bLane);
    end
  end

  always_comb begin
    unique case (ctl.kind)
      K_SEXT:   dpOut = ctl.wide ? {{(DATA_W-16){opB[15]}}, opB[15:0]}
                                 : {{(DATA_W-8){opB[7]}}, opB[7:0]};
      K_POP:    dpOut = DATA_W'(onesCount);
      K_LEAD:   dpOut = DATA_W'(leadZeros);
      K_TRAIL:  dpOut = DATA_W'(trailZeros);
      K_SAD:    dpOut = DATA_W'(sadSum);
      K_SPREAD: dpOut = ctl.wide ? spread32 : spread16;
      K_GATHER: dpOut = ctl.wide ? gather32 : gather16;
      K_MINMAX: dpOut = ctl.wide ? mmRes[1] : mmRes[0];
      default:  dpOut = '0;
    endcase
  end

endmodule

// File: rtl/lane_bitops_unit.sv
module lane_bitops_unit
  import lbu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [6:0]        funcCode,
  input  logic              aFieldIsZeroReg,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);

  laneCtl_t          ctl;
  logic [DATA_W-1:0] dpOut;

  lbu_control control (
    .funcCode        (funcCode),
    .aFieldIsZeroReg (aFieldIsZeroReg),
    .ctl             (ctl)
  );

  lbu_datapath #(.DATA_W(DATA_W)) datapath (
    .ctl   (ctl),
    .opA   (opA),
    .opB   (opB),
    .dpOut (dpOut)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      result   <= '0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result  <= ctl.illegal ? '0 : dpOut;
        illegal <= ctl.illegal;
      end
    end
  end

  a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(result) && $stable(illegal)));
  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && illegal) |-> (result == '0));
  a_r9_bad_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && funcCode[6:1] == 6'h00 && !aFieldIsZeroReg) |=> illegal);
  a_r3_zero_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && funcCode == 7'h32 && opB == '0) |=> (result == DATA_W'(DATA_W)));
  a_r2_pop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && funcCode == 7'h30) |=> (result <= DATA_W'(DATA_W)));
  a_r6_gather_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && funcCode[6:1] == 6'h1b) |=> (result[DATA_W-1:DATA_W/2] == '0));

endmodule

// File: tb/lane_bitops_unit_test.sv
`timescale 1ns/1ps
module lane_bitops_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [6:0]  funcCode = '0;
  logic        aFieldIsZeroReg = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic        outValid, illegal;
  logic [63:0] result;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lane_bitops_unit uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .funcCode(funcCode),
    .aFieldIsZeroReg(aFieldIsZeroReg), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .illegal(illegal)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tagFor(logic [6:0] c, bit f);
    if (c <= 7'h01) return f ? "R1" : "R9";
    case (c)
      7'h30: return "R2";
      7'h31: return "R4";
      7'h32, 7'h33: return "R3";
      7'h34, 7'h35: return "R5";
      7'h36, 7'h37: return "R6";
      7'h38, 7'h39, 7'h3a, 7'h3b: return "R7";
      7'h3c, 7'h3d, 7'h3e, 7'h3f: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic longint laneVal(logic [63:0] x, int pos, int w, bit sgn);
    longint v;
    v = longint'((x >> pos) & ((64'd1 << w) - 1));
    if (sgn && v >= (longint'(1) << (w - 1))) v = v - (longint'(1) << w);
    return v;
  endfunction

  function automatic logic [63:0] refCalc(logic [6:0] c, bit f,
                                          logic [63:0] a, logic [63:0] b,
                                          output bit ill);
    logic [63:0] r;
    r = '0;
    ill = 1'b0;
    case (c)
      7'h00: if (f) r = longint'($signed(b[7:0]));  else ill = 1;
      7'h01: if (f) r = longint'($signed(b[15:0])); else ill = 1;
      7'h30: for (int i = 0; i < 64; i++) r += b[i];
      7'h31: for (int i = 0; i < 8; i++) begin
               longint d;
               d = laneVal(a, 8*i, 8, 0) - laneVal(b, 8*i, 8, 0);
               r += (d < 0) ? -d : d;
             end
      7'h32: begin int n; n = 0;
               while (n < 64 && !b[63-n]) n++;
               r = n; end
      7'h33: begin int n; n = 0;
               while (n < 64 && !b[n]) n++;
               r = n; end
      7'h34: for (int i = 0; i < 4; i++) r |= ((b >> (8*i)) & 64'hff) << (16*i);
      7'h35: for (int i = 0; i < 2; i++) r |= ((b >> (8*i)) & 64'hff) << (32*i);
      7'h36: for (int i = 0; i < 4; i++) r |= ((b >> (16*i)) & 64'hff) << (8*i);
      7'h37: for (int i = 0; i < 2; i++) r |= ((b >> (32*i)) & 64'hff) << (8*i);
      7'h38, 7'h39, 7'h3a, 7'h3b, 7'h3c, 7'h3d, 7'h3e, 7'h3f: begin
        int  w;
        bit  sgn, mx;
        w   = c[0] ? 16 : 8;
        mx  = (c >= 7'h3c);
        sgn = (c == 7'h38 || c == 7'h39 || c == 7'h3e || c == 7'h3f);
        for (int p = 0; p < 64; p += w) begin
          longint va, vb;
          bit takeA;
          va = laneVal(a, p, w, sgn);
          vb = laneVal(b, p, w, sgn);
          takeA = mx ? (va > vb) : (va < vb);
          r |= (((takeA ? a : b) >> p) & ((64'd1 << w) - 1)) << p;
        end
      end
      default: ill = 1;
    endcase
    return r;
  endfunction

  task automatic runOp(logic [6:0] c, bit f, logic [63:0] a, logic [63:0] b);
    bit ill;
    logic [63:0] exp;
    string t;
    exp = refCalc(c, f, a, b, ill);
    t = tagFor(c, f);
    @(negedge clk);
    inValid = 1; funcCode = c; aFieldIsZeroReg = f; opA = a; opB = b;
    @(posedge clk); #1;
    check({t, " result"}, result, exp);
    check({t, " illegal"}, {63'd0, illegal}, {63'd0, ill});
    check("R10 outValid", {63'd0, outValid}, 64'd1);
  endtask

  logic [63:0] rng = 64'h9e3779b97f4a7c15;
  function automatic logic [63:0] nextRand(logic [63:0] s);
    s ^= s << 13; s ^= s >> 7; s ^= s << 17;
    return s;
  endfunction

  initial begin
    #400000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [63:0] pa [12];
    logic [63:0] pb [12];
    logic [63:0] held;
    pa = '{64'h0, 64'hffffffffffffffff, 64'h8000000000000000, 64'h7f80ff017fff8000,
           64'h0123456789abcdef, 64'h00000000000000ff, 64'h8080808080808080, 64'h1,
           64'hfedcba9876543210, 64'h7f7f7f7f7f7f7f7f, 64'h0000000100000000, 64'haaaa5555ffff0000};
    pb = '{64'h0, 64'h0, 64'h0000000000000001, 64'h807f01ff8000ffff,
           64'hffffffffffffffff, 64'h8000000000000000, 64'h7f7f7f7f7f7f7f7f, 64'h0000000000000080,
           64'h0000000000008000, 64'h8080808080808080, 64'h0000010000000000, 64'h5555aaaa0000ffff};

    repeat (3) @(posedge clk);
    #1;
    check("R10 reset outValid", {63'd0, outValid}, 64'd0);
    check("R10 reset result", result, 64'd0);
    check("R10 reset illegal", {63'd0, illegal}, 64'd0);
    @(negedge clk); rst_n = 1;

    // Sweep every code, both flag values, corner then random operands
    for (int c = 0; c < 128; c++) begin
      for (int f = 0; f < 2; f++) begin
        for (int k = 0; k < 12; k++) runOp(7'(c), f[0], pa[k], pb[k]);
        for (int k = 0; k < 6; k++) begin
          logic [63:0] ra, rb;
          rng = nextRand(rng); ra = rng;
          rng = nextRand(rng); rb = rng;
          if (k[0]) rb = rb >> (rng[5:0]);
          runOp(7'(c), f[0], ra, rb);
        end
      end
    end

    // Single-bit inputs for both count trees
    for (int i = 0; i < 64; i++) begin
      runOp(7'h32, 0, 64'h0, 64'd1 << i);
      runOp(7'h33, 1, 64'h0, 64'd1 << i);
    end

    // R10: output holds while idle
    runOp(7'h30, 0, 64'h0, 64'h00000000000000ff);
    held = result;
    @(negedge clk);
    inValid = 0; funcCode = 7'h7f; opB = 64'hffffffffffffffff;
    @(posedge clk); #1;
    check("R10 idle outValid", {63'd0, outValid}, 64'd0);
    check("R10 idle result hold", result, held);
    check("R10 idle illegal hold", {63'd0, illegal}, 64'd0);
    @(posedge clk); #1;
    check("R10 idle result hold 2", result, 64'd8);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule